// File: doc/BRIEF.md
# Command-Driven I2C Master Engine

This block is a single-master I2C controller that software runs one bus action at a time. Software loads a byte into a data register and writes one command word. The command can open a transfer with a START and send the byte, send a byte on its own, receive a byte and answer it with ACK or NACK, close the transfer with a STOP, or free a bus that a stuck target is holding low. Each completed action raises its own sticky status flag. Software clears these flags by writing ones. Any flag whose enable bit is set drives the interrupt line.

The engine drives SCL and SDA as open-drain lines through two output-enable pins, where a high enable pulls the line low. It reads the lines back through two inputs. A `tick` strobe from outside sets the bus pace: every bit takes four ticks, with SCL low for the first two and high for the last two. Incoming SDA is sampled on the tick that ends the high half. After a byte the engine keeps SCL low, so a new START issued before any STOP becomes a repeated START.

Register offsets (`regAddr`): 0 is command/line state, 1 is data, 2 is status, 3 is interrupt enable.

Top module: `i2c_cmd_master`

## Requirements
- R1: A command word with bit 0 (start) set generates a START condition (SDA falls while SCL is high). The engine then shifts out data-register bits [7:0] MSB first and adds a ninth bit in which it releases SDA.
- R2: After every transmitted byte, exactly one of two status bits is set: bit 0 if SDA read low in the ninth bit (ACK), bit 1 if SDA read high (NACK).
- R3: Command bit 2 (receive) shifts in eight bits MSB first, stores them in data-register bits [15:8], drives SDA low in the ninth bit (ACK) and sets status bit 2.
- R4: When command bit 3 (last) is set with a receive, the engine releases SDA in the ninth bit (NACK) instead of driving it low.
- R5: Command bit 4 (stop) produces a STOP condition (SDA rises while SCL is high), leaves both lines released and sets status bit 3.
- R6: Command bit 5 (recover) pulses SCL and samples SDA at the end of each high half. Once SDA reads high, the engine issues a STOP and sets status bit 4. If SDA is still low after MAX_PULSES pulses (9 by default), it sets status bits 4 and 5 together and issues no STOP. Recover takes priority over stop, which takes priority over start, then transmit, then receive.
- R7: A command written while the engine is busy is ignored and sets status bit 5 (abnormal).
- R8: The status register is write-one-to-clear. Writing a zero leaves the matching bit unchanged.
- R9: `irq` is high exactly when some status bit and its interrupt-enable bit (register 3, same position) are both set.
- R10: Reading register 0 returns the live SCL level in bit 16, the live SDA level in bit 17 and the busy state in bit 18.
- R11: A start command issued after a byte, with no STOP in between, first releases SDA, then raises SCL, then produces a START (a repeated START) without any STOP.
- R12: Each bit spans four tick periods. SCL rises on the second tick of the bit and falls on the fourth, so it stays high for two tick periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bus pacing strobe, one cycle wide |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register select |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational) |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclOe | output | 1 | Pull SCL low when high |
| sdaOe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
The bench connects the engine to a behavioural target on a wired-AND bus. It sweeps every byte value 0 to 255 through the transmit path, so a bit-order slip, a dropped bit or a stuck data bit each show up as a wrong byte at the target. An address with ACK and a byte that the target answers with NACK separate the two result flags. A read of four bytes from a counting pattern, the last one marked as last, tells ACK from NACK on the master side and catches misplaced receive data. Recovery runs once against a target that frees SDA after three pulses and once against a target that never frees it; the number of SCL rising edges separates the STOP path from the give-up path. An interrupt sweep over all 64 enable masks checks the masking.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int CMD_W = 6;
  localparam int NFLAG = 6;

  // command bit positions
  localparam int C_START = 0;
  localparam int C_TX    = 1;
  localparam int C_RX    = 2;
  localparam int C_LAST  = 3;
  localparam int C_STOP  = 4;
  localparam int C_REC   = 5;

  // status flag positions
  localparam int F_ACK  = 0;
  localparam int F_NAK  = 1;
  localparam int F_RXD  = 2;
  localparam int F_STOP = 3;
  localparam int F_REC  = 4;
  localparam int F_ABN  = 5;

  // register offsets and readback bit positions
  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_EN   = 2'd3;
  localparam int LV_SCL  = 16;
  localparam int LV_SDA  = 17;
  localparam int LV_BUSY = 18;

  typedef enum logic [3:0] {
    S_IDLE, S_RS_A, S_RS_B, S_ST_A, S_ST_B, S_BYTE,
    S_SP_A, S_SP_B, S_SP_C, S_SP_D, S_RC_LO, S_RC_HI, S_RC_CHK
  } ctrlState_t;

  typedef struct packed {
    logic             loadShift;
    logic             shiftEn;
    logic             shiftBit;
    logic             captureRx;
    logic [NFLAG-1:0] setFlag;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_cmd_datapath.sv
module i2c_cmd_datapath
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              busy,
  input  dpStrobe_t         strobe,
  output logic              cmdValid,
  output logic [CMD_W-1:0]  cmdBits,
  output logic              txBit,
  output logic              irq
);
  localparam logic [NFLAG-1:0] ABN_MASK = NFLAG'(1) << F_ABN;

  logic [7:0]       txByte, rxByte, shifter;
  logic [NFLAG-1:0] status, enable, setAll, clrMask;

  assign cmdValid = regWe && (regAddr == A_CMD) && (|regWdata[CMD_W-1:0]);
  assign cmdBits  = regWdata[CMD_W-1:0];
  assign txBit    = shifter[7];
  assign setAll   = strobe.setFlag | ((cmdValid && busy) ? ABN_MASK : '0);
  assign clrMask  = (regWe && (regAddr == A_STAT)) ? regWdata[NFLAG-1:0] : '0;
  assign irq      = |(status & enable);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte  <= '0;
      rxByte  <= '0;
      shifter <= '0;
      status  <= '0;
      enable  <= '0;
    end else begin
      if (regWe && (regAddr == A_DATA)) txByte <= regWdata[7:0];
      if (regWe && (regAddr == A_EN))   enable <= regWdata[NFLAG-1:0];
      if (strobe.loadShift)       shifter <= txByte;
      else if (strobe.shiftEn)    shifter <= {shifter[6:0], strobe.shiftBit};
      if (strobe.captureRx)       rxByte  <= {shifter[6:0], strobe.shiftBit};
      status <= (status & ~clrMask) | setAll;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      A_CMD: begin
        regRdata[LV_SCL]  = sclIn;
        regRdata[LV_SDA]  = sdaIn;
        regRdata[LV_BUSY] = busy;
      end
      A_DATA: begin
        regRdata[7:0]  = txByte;
        regRdata[15:8] = rxByte;
      end
      A_STAT:  regRdata[NFLAG-1:0] = status;
      default: regRdata[NFLAG-1:0] = enable;
    endcase
  end

  // R7: a command arriving while busy marks the abnormal flag
  a_r7_busy_abnormal: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && busy |=> status[F_ABN]);

  // R8: writing all ones with nothing being set empties the status register
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    regWe && regAddr == A_STAT && (&regWdata[NFLAG-1:0]) && strobe.setFlag == '0
      |=> status == '0);
endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter int MAX_PULSES = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdBits,
  input  logic             sdaIn,
  input  logic             txBit,
  output logic             busy,
  output logic             sclOe,
  output logic             sdaOe,
  output dpStrobe_t        strobe
);
  localparam int PC_W = $clog2(MAX_PULSES + 1);

  ctrlState_t      state;
  logic [1:0]      phase;
  logic [3:0]      bitCnt;
  logic            isRx, rxLast, held, fromRec;
  logic [PC_W-1:0] pulseCnt;
  logic            acceptCmd, bitEnd;

  assign busy      = (state != S_IDLE);
  assign acceptCmd = cmdValid && !busy;
  assign bitEnd    = tick && (state == S_BYTE) && (phase == 2'd3);

  always_comb begin
    strobe           = '0;
    strobe.loadShift = acceptCmd && !cmdBits[C_REC] && !cmdBits[C_STOP]
                       && (cmdBits[C_START] || cmdBits[C_TX]);
    strobe.shiftEn   = bitEnd && (bitCnt < 4'd8);
    strobe.shiftBit  = sdaIn;
    strobe.captureRx = bitEnd && (bitCnt == 4'd7) && isRx;
    if (bitEnd && bitCnt == 4'd8) begin
      if (isRx)       strobe.setFlag[F_RXD] = 1'b1;
      else if (sdaIn) strobe.setFlag[F_NAK] = 1'b1;
      else            strobe.setFlag[F_ACK] = 1'b1;
    end
    if (tick && state == S_SP_D) begin
      if (fromRec) strobe.setFlag[F_REC]  = 1'b1;
      else         strobe.setFlag[F_STOP] = 1'b1;
    end
    if (tick && state == S_RC_CHK && !sdaIn && pulseCnt == PC_W'(MAX_PULSES - 1)) begin
      strobe.setFlag[F_REC] = 1'b1;
      strobe.setFlag[F_ABN] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phase    <= '0;
      bitCnt   <= '0;
      isRx     <= 1'b0;
      rxLast   <= 1'b0;
      held     <= 1'b0;
      fromRec  <= 1'b0;
      pulseCnt <= '0;
      sclOe    <= 1'b0;
      sdaOe    <= 1'b0;
    end else if (acceptCmd) begin
      phase    <= '0;
      bitCnt   <= '0;
      pulseCnt <= '0;
      if (cmdBits[C_REC]) state <= S_RC_LO;
      else if (cmdBits[C_STOP]) begin
        state   <= S_SP_A;
        fromRec <= 1'b0;
      end else if (cmdBits[C_START]) begin
        state <= held ? S_RS_A : S_ST_A;
        isRx  <= 1'b0;
      end else if (cmdBits[C_TX]) begin
        state <= S_BYTE;
        isRx  <= 1'b0;
      end else begin
        state  <= S_BYTE;
        isRx   <= 1'b1;
        rxLast <= cmdBits[C_LAST];
      end
    end else if (tick) begin
      unique case (state)
        S_RS_A: begin sdaOe <= 1'b0; state <= S_RS_B; end
        S_RS_B: begin sclOe <= 1'b0; state <= S_ST_A; end
        S_ST_A: begin sdaOe <= 1'b1; state <= S_ST_B; end
        S_ST_B: begin sclOe <= 1'b1; held <= 1'b1; state <= S_BYTE; end
        S_BYTE: begin
          phase <= phase + 2'd1;
          unique case (phase)
            2'd0: begin
              sclOe <= 1'b1;
              if (bitCnt == 4'd8) sdaOe <= isRx && !rxLast;
              else                sdaOe <= !isRx && !txBit;
            end
            2'd1: sclOe <= 1'b0;
            2'd3: begin
              sclOe <= 1'b1;
              held  <= 1'b1;
              if (bitCnt == 4'd8) state <= S_IDLE;
              else                bitCnt <= bitCnt + 4'd1;
            end
            default: ;
          endcase
        end
        S_SP_A: begin sclOe <= 1'b1; state <= S_SP_B; end
        S_SP_B: begin sdaOe <= 1'b1; state <= S_SP_C; end
        S_SP_C: begin sclOe <= 1'b0; state <= S_SP_D; end
        S_SP_D: begin sdaOe <= 1'b0; held <= 1'b0; state <= S_IDLE; end
        S_RC_LO: begin sclOe <= 1'b1; sdaOe <= 1'b0; state <= S_RC_HI; end
        S_RC_HI: begin sclOe <= 1'b0; state <= S_RC_CHK; end
        S_RC_CHK: begin
          pulseCnt <= pulseCnt + PC_W'(1);
          if (sdaIn) begin
            state   <= S_SP_A;
            fromRec <= 1'b1;
          end else if (pulseCnt == PC_W'(MAX_PULSES - 1)) begin
            state <= S_IDLE;
            held  <= 1'b0;
          end else state <= S_RC_LO;
        end
        default: ;
      endcase
    end
  end

  // R2: a byte result is never both ACK and NACK
  a_r2_single_result: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.setFlag[F_NAK:F_ACK]));

  // R5: once a stop completes both lines are released
  a_r5_lines_free: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setFlag[F_STOP] |=> !sclOe && !sdaOe);

  // R6: recovery never goes beyond its pulse budget
  a_r6_pulse_limit: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PC_W'(MAX_PULSES));

  // R1: data bits hold still while SCL is released inside a byte
  a_r1_sda_steady: assert property (@(posedge clk) disable iff (!rstN)
    state == S_BYTE && !sclOe && $past(state == S_BYTE && !sclOe) |-> $stable(sdaOe));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int MAX_PULSES = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              regWe,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              irq
);
  dpStrobe_t        strobe;
  logic             cmdValid, txBit, busy;
  logic [CMD_W-1:0] cmdBits;

  i2c_cmd_ctrl #(.MAX_PULSES(MAX_PULSES)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cmdValid(cmdValid), .cmdBits(cmdBits),
    .sdaIn(sdaIn), .txBit(txBit), .busy(busy), .sclOe(sclOe), .sdaOe(sdaOe),
    .strobe(strobe)
  );

  i2c_cmd_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .sclIn(sclIn), .sdaIn(sdaIn), .busy(busy), .strobe(strobe),
    .cmdValid(cmdValid), .cmdBits(cmdBits), .txBit(txBit), .irq(irq)
  );
endmodule

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
  logic        clk = 1'b0, rstN = 1'b0, tick = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        sclOe, sdaOe, irq;
  int          stuckPulses = 0;
  logic        tSda = 1'b1;
  wire         sclBus = ~sclOe;
  wire         sdaBus = ~sdaOe & tSda & (stuckPulses == 0);

  int nChecks = 0, nFail = 0;
  logic [1:0] tdiv = 2'd0;

  always #10 clk = ~clk;
  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  i2c_cmd_master dut (
    .clk(clk), .rstN(rstN), .tick(tick), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq)
  );

  // behavioural target
  logic       active = 1'b0, rdMode = 1'b0, masterAck = 1'b0;
  logic [7:0] shiftIn = '0, lastByte = '0, rdBase = 8'h3C;
  int bitPos = 0, byteNo = 0, nakByte = -1, rxCount = 0;
  int startCnt = 0, stopCnt = 0, sclRises = 0;
  time lastRise = 0, prevRise = 0, lastFall = 0;

  always @(negedge sdaBus) if (sclBus === 1'b1 && stuckPulses == 0) begin
    active = 1'b1; bitPos = -1; byteNo = 0; rdMode = 1'b0; tSda = 1'b1; startCnt++;
  end
  always @(posedge sdaBus) if (sclBus === 1'b1) begin
    active = 1'b0; tSda = 1'b1; stopCnt++;
  end
  always @(posedge sclBus) begin
    sclRises++; prevRise = lastRise; lastRise = $time;
    if (stuckPulses > 0) stuckPulses--;
    if (active) begin
      if (bitPos >= 0 && bitPos < 8) shiftIn = {shiftIn[6:0], sdaBus};
      else if (bitPos == 8) masterAck = sdaBus;
    end
  end
  always @(negedge sclBus) begin
    lastFall = $time;
    if (active) begin
      if (bitPos == 8) begin
        if (byteNo == 0) rdMode = shiftIn[0];
        if (!(rdMode && byteNo > 0)) begin lastByte = shiftIn; rxCount++; end
        if (rdMode && byteNo > 0 && masterAck) active = 1'b0;
        byteNo++; bitPos = 0;
      end else bitPos++;
      if (!active) tSda = 1'b1;
      else if (bitPos == 8) tSda = (rdMode && byteNo > 0) ? 1'b1 : (byteNo == nakByte);
      else begin
        logic [7:0] v;
        v = rdBase + 8'(byteNo);
        tSda = (rdMode && byteNo > 0) ? v[7 - bitPos] : 1'b1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(2'd0, d);
      if (!d[18]) return;
    end
    chk("busy timeout", 32'd1, 32'd0);
  endtask

  task automatic doCmd(input logic [31:0] c);
    wr(2'd0, c);
    waitIdle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int s0, r0, c0;
    repeat (4) @(posedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);

    // reset state
    rd(2'd2, d); chk("R8 reset status", d, 32'h0);
    rd(2'd0, d); chk("R10 reset lines", d, 32'h0003_0000);
    chk("R9 reset irq", {31'b0, irq}, 32'h0);
    chk("R5 reset oe", {30'b0, sclOe, sdaOe}, 32'h0);

    // address with ACK
    wr(2'd3, 32'h3F);
    s0 = startCnt;
    wr(2'd1, 32'hA4);
    doCmd(32'h03);
    chk("R1 start seen", startCnt - s0, 1);
    chk("R1 address byte", lastByte, 32'hA4);
    rd(2'd2, d); chk("R2 ack flag", d, 32'h01);
    chk("R9 irq on ack", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'h3F);
    rd(2'd2, d); chk("R8 clear all", d, 32'h0);

    // sweep every byte value
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 32'(v));
      doCmd(32'h02);
      chk("R1 tx byte", lastByte, 32'(v));
      rd(2'd2, d); chk("R2 tx ack", d, 32'h01);
      wr(2'd2, 32'h3F);
    end
    chk("R12 bit period", 32'(lastRise - prevRise), 32'd320);
    chk("R12 high time", 32'(lastFall - lastRise), 32'd160);

    // NACK from target
    nakByte = byteNo;
    wr(2'd1, 32'h5A);
    doCmd(32'h02);
    rd(2'd2, d); chk("R2 nack flag", d, 32'h02);
    nakByte = -1;
    wr(2'd2, 32'h3F);

    // command while busy
    c0 = rxCount;
    wr(2'd1, 32'h11);
    wr(2'd0, 32'h02);
    wr(2'd0, 32'h02);
    waitIdle();
    rd(2'd2, d); chk("R7 abnormal set", d, 32'h21);
    repeat (200) @(negedge clk);
    chk("R7 one byte only", rxCount - c0, 1);
    wr(2'd2, 32'h3F);

    // repeated start and reads
    s0 = startCnt; r0 = stopCnt;
    wr(2'd1, 32'hA5);
    doCmd(32'h03);
    chk("R11 repeated start", startCnt - s0, 1);
    chk("R11 no stop", stopCnt - r0, 0);
    rd(2'd2, d); chk("R2 read addr ack", d, 32'h01);
    wr(2'd2, 32'h3F);
    for (int k = 1; k <= 4; k++) begin
      doCmd(k == 4 ? 32'h0C : 32'h04);
      rd(2'd1, d); chk("R3 rx data", d[15:8], 32'(8'(rdBase + 8'(k))));
      rd(2'd2, d); chk("R3 rx done", d, 32'h04);
      if (k == 4) chk("R4 master nack", {31'b0, masterAck}, 32'h1);
      else        chk("R3 master ack", {31'b0, masterAck}, 32'h0);
      wr(2'd2, 32'h3F);
    end

    // stop
    r0 = stopCnt;
    doCmd(32'h10);
    chk("R5 stop seen", stopCnt - r0, 1);
    rd(2'd2, d); chk("R5 stop flag", d, 32'h08);
    chk("R5 lines free", {30'b0, sclOe, sdaOe}, 32'h0);
    rd(2'd0, d); chk("R10 idle levels", d[17:16], 32'h3);

    // interrupt masking and partial clear
    for (int e = 0; e < 64; e++) begin
      wr(2'd3, 32'(e));
      @(negedge clk);
      chk("R9 irq mask", {31'b0, irq}, {31'b0, e[3]});
    end
    wr(2'd2, 32'h37);
    rd(2'd2, d); chk("R8 zero bits keep", d, 32'h08);
    wr(2'd2, 32'h08);
    rd(2'd2, d); chk("R8 w1c", d, 32'h0);
    wr(2'd3, 32'h3F);
    @(negedge clk); chk("R9 irq none", {31'b0, irq}, 32'h0);

    // recovery that succeeds
    stuckPulses = 3;
    rd(2'd0, d); chk("R10 sda low live", d[17:16], 32'h1);
    r0 = sclRises;
    doCmd(32'h20);
    rd(2'd2, d); chk("R6 recover ok", d, 32'h10);
    chk("R6 pulses plus stop", sclRises - r0, 4);
    rd(2'd0, d); chk("R10 sda freed", d[17:16], 32'h3);
    wr(2'd2, 32'h3F);

    // recovery that gives up
    stuckPulses = 20;
    r0 = sclRises;
    doCmd(32'h20);
    rd(2'd2, d); chk("R6 recover fail", d, 32'h30);
    chk("R6 pulse budget", sclRises - r0, 9);
    stuckPulses = 0;
    wr(2'd2, 32'h3F);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule